// File: doc/BRIEF.md
# Two-Deep Transmit Command Chaining Controller

This block sits between a host command path and the packet transmitter of a token-passing network node. The host writes "send page N" commands. The block keeps them in a two-entry queue, oldest first. When a token arrives, it asks the transmitter to send the oldest waiting page. When that transmission ends, the next queued page goes out on the next token, with no further host action. A host drop command removes the oldest queued entry.

Each finished transmission reports a completion flag and an acknowledge flag. These are double-buffered. If a second result arrives while the first is still shown, the second is held back. It appears only after the host clears the first, and only once a minimum idle time has passed. The interrupt is the shown completion flag ANDed with an enable input. It stays asserted until the host issues the clear command.

With the chaining input low, the queue holds a single entry. A send command that finds no free slot is discarded, and a sticky overflow flag records the loss.

Top module: `txq_chain_ctrl`

## Requirements
- R1: A send command (`cmd_op` = 1 with `cmd_valid`) is stored when a slot is free after any removal in the same cycle. Capacity is 2 with `chain_en` high and 1 with it low. `tx_avail` is 0 while any command is held and 1 when the queue is empty.
- R2: A send command that finds no free slot is discarded without changing the queue, and `ovf_flag` is set. `ovf_flag` then stays 1 until reset.
- R3: `start_req` is a one-cycle pulse in the cycle after `token_rx`. It fires only when the oldest entry is waiting and not yet started, and `start_page` then carries that entry's page. At most one transmission is in flight, so a token during a transmission starts nothing.
- R4: After `tx_done` for the in-flight entry, the next queued entry starts on the next token. Pages go out in issue order.
- R5: A `tx_done` for the in-flight entry sets `done_flag`, and `ack_flag` shows the `tx_ack` value sampled with that `tx_done`. `ack_flag` is 0 whenever `done_flag` is 0.
- R6: `done_flag` and `irq` fall only on the clear command (`cmd_op` = 3). No other command, token or completion lowers them. A clear issued while `done_flag` is 0 has no visible effect.
- R7: A result that completes while another is shown, or during the idle window, is held back. It is shown later with its own ack value, in completion order.
- R8: After a clear, `done_flag` and `irq` stay low for at least GAP_CYC cycles before the next result is shown. A held result appears exactly GAP_CYC+1 cycles after the clear takes effect.
- R9: `irq` equals `done_flag` AND `irq_en`. The enable input does not change `done_flag`.
- R10: A drop command (`cmd_op` = 2) removes the oldest entry, and two drops empty a full queue. A drop on an empty queue does nothing, and a `tx_done` with nothing in flight is ignored.
- R11: After reset, `done_flag`, `ack_flag`, `irq`, `ovf_flag` and `start_req` are 0 and `tx_avail` is 1.
- R12: A waiting entry does not start while a result is held back. It can start on a token once that result has been shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en | input | 1 | 1 allows two queued commands, 0 allows one |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 none, 1 send, 2 drop oldest, 3 clear completion |
| cmd_page | input | PAGE_W | Page number for a send command |
| token_rx | input | 1 | Token received pulse |
| tx_done | input | 1 | Transmission finished pulse |
| tx_ack | input | 1 | Acknowledge result, sampled with tx_done |
| start_req | output | 1 | Start-transmission pulse |
| start_page | output | PAGE_W | Page to send, valid with start_req |
| tx_avail | output | 1 | 1 when no command is held |
| done_flag | output | 1 | Shown completion flag |
| ack_flag | output | 1 | Acknowledge of the shown completion |
| ovf_flag | output | 1 | Sticky flag for a discarded send command |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- `start_req` is a single-cycle pulse caused by a token.
- No start happens while a result is held back.
- `irq` never rises without `done_flag`, and `ack_flag` never shows without it.
- The completion flag falls only after a clear command.
- The overflow flag never drops.
- A counter in the checker measures the low time before each re-assertion of the completion flag.

Only the bench scenarios can show the following:
- Pages leave in issue order, with the right ack attached to each result.
- Drops remove the right entry.
- Discarded commands never start.
- A held result appears after exactly the idle window.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_SEND   = 2'd1,
    OP_DROP   = 2'd2,
    OP_ACKCLR = 2'd3
  } txq_op_e;

  // Usable queue slots: full depth when chaining, otherwise one.
  function automatic int unsigned slot_cap(input logic chain, input int unsigned depth);
    return chain ? depth : 1;
  endfunction

  // Cycles the completion flag stays low from clear to the next show.
  function automatic int unsigned min_low_cycles(input int unsigned gap);
    return gap + 1;
  endfunction

endpackage

// File: rtl/txq_slots.sv
module txq_slots
  import txq_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_en,
  input  logic              push,
  input  logic [PAGE_W-1:0] push_page,
  input  logic              pop,
  input  logic              launch,
  output logic              push_ok,
  output logic              push_drop,
  output logic              head_valid,
  output logic              head_busy,
  output logic [PAGE_W-1:0] head_page
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vld_q, sh_v, nx_v;
  logic [PAGE_W-1:0] pg_q [DEPTH];
  logic [PAGE_W-1:0] sh_p [DEPTH];
  logic [PAGE_W-1:0] nx_p [DEPTH];
  logic [CNT_W-1:0]  fill_after, cap;
  logic              busy_q;

  assign cap        = CNT_W'(slot_cap(chain_en, DEPTH));
  assign fill_after = CNT_W'($countones(sh_v));
  assign push_ok    = push & (fill_after < cap);
  assign push_drop  = push & ~push_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i + 1 < DEPTH) begin : g_mid
      assign sh_v[i] = pop ? vld_q[i+1] : vld_q[i];
      assign sh_p[i] = pop ? pg_q[i+1]  : pg_q[i];
    end else begin : g_last
      assign sh_v[i] = pop ? 1'b0 : vld_q[i];
      assign sh_p[i] = pg_q[i];
    end
    assign nx_v[i] = sh_v[i] | (push_ok && fill_after == CNT_W'(i));
    assign nx_p[i] = (push_ok && fill_after == CNT_W'(i)) ? push_page : sh_p[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      busy_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) pg_q[i] <= '0;
    end else begin
      vld_q <= nx_v;
      for (int i = 0; i < DEPTH; i++) pg_q[i] <= nx_p[i];
      if (pop)         busy_q <= 1'b0;
      else if (launch) busy_q <= 1'b1;
    end
  end

  assign head_valid = vld_q[0];
  assign head_page  = pg_q[0];
  assign head_busy  = busy_q;
endmodule

// File: rtl/txq_status.sv
module txq_status #(
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic comp,
  input  logic comp_ack,
  input  logic clr,
  output logic done_q,
  output logic ack_q,
  output logic held_valid,
  output logic show_evt
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  logic             held_q, held_ack_q;
  logic [GAP_W-1:0] gap_q;
  logic             gap_open, can_show, clr_eff, show_new, show_held, park;

  assign gap_open  = (gap_q == '0);
  assign can_show  = ~done_q & gap_open;
  assign clr_eff   = clr & done_q;
  assign show_new  = comp & can_show & ~held_q;
  assign show_held = held_q & can_show;
  assign park      = comp & ~show_new;
  assign show_evt  = show_new | show_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      ack_q      <= 1'b0;
      held_q     <= 1'b0;
      held_ack_q <= 1'b0;
      gap_q      <= '0;
    end else begin
      if (clr_eff) begin
        done_q <= 1'b0;
        gap_q  <= GAP_W'(GAP_CYC);
      end else if (!gap_open) begin
        gap_q  <= gap_q - 1'b1;
      end
      if (show_new) begin
        done_q <= 1'b1;
        ack_q  <= comp_ack;
      end else if (show_held) begin
        done_q <= 1'b1;
        ack_q  <= held_ack_q;
        held_q <= 1'b0;
      end
      if (park) begin
        held_q     <= 1'b1;
        held_ack_q <= comp_ack;
      end
    end
  end

  assign held_valid = held_q;
endmodule

// File: rtl/txq_chain_ctrl.sv
module txq_chain_ctrl
  import txq_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int DEPTH   = 2,
  parameter int GAP_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_en,
  input  logic              irq_en,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              token_rx,
  input  logic              tx_done,
  input  logic              tx_ack,
  output logic              start_req,
  output logic [PAGE_W-1:0] start_page,
  output logic              tx_avail,
  output logic              done_flag,
  output logic              ack_flag,
  output logic              ovf_flag,
  output logic              irq
);
  logic              cmd_send, cmd_drop, cmd_clr;
  logic              push_ok, push_drop, head_valid, head_busy;
  logic [PAGE_W-1:0] head_page;
  logic              tx_complete, pop, launch;
  logic              held_valid, show_evt, ack_raw;
  logic              start_q, ovf_q;
  logic [PAGE_W-1:0] start_page_q;

  assign cmd_send = cmd_valid && (cmd_op == OP_SEND);
  assign cmd_drop = cmd_valid && (cmd_op == OP_DROP);
  assign cmd_clr  = cmd_valid && (cmd_op == OP_ACKCLR);

  assign tx_complete = tx_done & head_busy;
  assign pop         = tx_complete | (cmd_drop & head_valid);
  assign launch      = token_rx & head_valid & ~head_busy & ~held_valid & ~cmd_drop;

  txq_slots #(.DEPTH(DEPTH), .PAGE_W(PAGE_W)) slots_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_en   (chain_en),
    .push       (cmd_send),
    .push_page  (cmd_page),
    .pop        (pop),
    .launch     (launch),
    .push_ok    (push_ok),
    .push_drop  (push_drop),
    .head_valid (head_valid),
    .head_busy  (head_busy),
    .head_page  (head_page)
  );

  txq_status #(.GAP_CYC(GAP_CYC)) status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .comp       (tx_complete),
    .comp_ack   (tx_ack),
    .clr        (cmd_clr),
    .done_q     (done_flag),
    .ack_q      (ack_raw),
    .held_valid (held_valid),
    .show_evt   (show_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q      <= 1'b0;
      start_page_q <= '0;
      ovf_q        <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) start_page_q <= head_page;
      if (push_drop) ovf_q <= 1'b1;
    end
  end

  assign start_req  = start_q;
  assign start_page = start_page_q;
  assign tx_avail   = ~head_valid;
  assign ack_flag   = done_flag & ack_raw;
  assign ovf_flag   = ovf_q;
  assign irq        = done_flag & irq_en;
endmodule

// File: rtl/txq_chain_chk.sv
module txq_chain_chk
  import txq_pkg::*;
#(
  parameter int GAP_CYC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       token_rx,
  input logic       start_req,
  input logic       held_valid,
  input logic       done_flag,
  input logic       ack_flag,
  input logic       ovf_flag,
  input logic       irq
);
  logic [15:0] low_run;
  logic        seen_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (done_flag)              low_run <= '0;
      else if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
      if ($fell(done_flag)) seen_fall <= 1'b1;
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);
  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(token_rx));
  // R12
  start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !$past(held_valid));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);
  // R5
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_flag |-> !ack_flag);
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(cmd_valid && (cmd_op == OP_ACKCLR)));
  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  // R8
  irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_flag) && seen_fall) |-> (low_run >= 16'(GAP_CYC)));
endmodule

bind txq_chain_ctrl txq_chain_chk #(.GAP_CYC(GAP_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .token_rx   (token_rx),
  .start_req  (start_req),
  .held_valid (held_valid),
  .done_flag  (done_flag),
  .ack_flag   (ack_flag),
  .ovf_flag   (ovf_flag),
  .irq        (irq)
);

// File: tb/txq_chain_ctrl_tb_top.sv
`timescale 1ns/1ps
module txq_chain_ctrl_tb_top;
  localparam int PW  = 4;
  localparam int GAP = 8;
  localparam logic [1:0] C_SEND = 2'd1, C_DROP = 2'd2, C_CLR = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chain_en = 1'b1, irq_en = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [PW-1:0] cmd_page = '0;
  logic token_rx = 1'b0, tx_done = 1'b0, tx_ack = 1'b0;
  logic start_req, tx_avail, done_flag, ack_flag, ovf_flag, irq;
  logic [PW-1:0] start_page;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  txq_chain_ctrl #(.PAGE_W(PW), .DEPTH(2), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .irq_en(irq_en),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .token_rx(token_rx), .tx_done(tx_done), .tx_ack(tx_ack),
    .start_req(start_req), .start_page(start_page), .tx_avail(tx_avail),
    .done_flag(done_flag), .ack_flag(ack_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [PW-1:0] pg);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic tok();
    @(negedge clk); token_rx = 1'b1;
    @(negedge clk); token_rx = 1'b0;
  endtask

  task automatic fin(input logic a);
    @(negedge clk); tx_done = 1'b1; tx_ack = a;
    @(negedge clk); tx_done = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_wait();
    issue(C_CLR, '0);
    idle(GAP + 2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R11 reset state
    check("R11 done", done_flag, 0);
    check("R11 ack", ack_flag, 0);
    check("R11 irq", irq, 0);
    check("R11 ovf", ovf_flag, 0);
    check("R11 start", start_req, 0);
    check("R11 avail", tx_avail, 1);
    rst_n = 1'b1;
    idle(2);

    // Sweep every page with both ack values: R1 R3 R5 R6 R9
    for (int p = 0; p < (1 << PW); p++) begin
      for (int a = 0; a < 2; a++) begin
        issue(C_SEND, PW'(p));
        check("R1 avail low", tx_avail, 0);
        tok();
        check("R3 start", start_req, 1);
        check("R3 page", start_page, p);
        fin(a[0]);
        check("R5 done", done_flag, 1);
        check("R5 ack", ack_flag, a);
        check("R9 irq", irq, 1);
        issue(C_CLR, '0);
        check("R6 done cleared", done_flag, 0);
        check("R6 irq cleared", irq, 0);
        check("R5 ack hidden", ack_flag, 0);
        idle(GAP + 2);
      end
    end
    // R3 pulse length
    issue(C_SEND, 4'd2);
    tok();
    idle(1);
    check("R3 pulse ends", start_req, 0);
    fin(1'b0);
    clr_wait();

    // Single-slot mode: R1 R2
    chain_en = 1'b0;
    issue(C_SEND, 4'd3);
    issue(C_SEND, 4'd5);
    check("R2 ovf set", ovf_flag, 1);
    tok();
    check("R1 page", start_page, 3);
    fin(1'b1);
    check("R1 empty after one", tx_avail, 1);
    clr_wait();
    tok();
    check("R1 second ignored", start_req, 0);
    chain_en = 1'b1;

    // Chaining, order, hold and gap: R2 R3 R4 R7 R8
    issue(C_SEND, 4'd6);
    issue(C_SEND, 4'd9);
    issue(C_SEND, 4'd12);
    check("R2 ovf sticky", ovf_flag, 1);
    tok();
    check("R3 first page", start_page, 6);
    tok();
    check("R3 one in flight", start_req, 0);
    fin(1'b1);
    check("R5 first done", done_flag, 1);
    check("R5 first ack", ack_flag, 1);
    check("R4 second waiting", tx_avail, 0);
    tok();
    check("R4 auto start", start_req, 1);
    check("R4 order", start_page, 9);
    fin(1'b0);
    check("R7 first still shown", ack_flag, 1);
    issue(C_CLR, '0);
    begin
      int cnt = 0;
      while (!irq && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      check("R8 gap length", cnt, GAP + 1);
    end
    check("R7 second shown", done_flag, 1);
    check("R7 second ack", ack_flag, 0);
    clr_wait();
    tok();
    check("R2 third never started", start_req, 0);
    check("R2 queue empty", tx_avail, 1);

    // Held result blocks start: R12 R7
    issue(C_SEND, 4'd1);
    issue(C_SEND, 4'd2);
    tok();
    fin(1'b1);
    tok();
    check("R4 page two", start_page, 2);
    fin(1'b0);
    issue(C_SEND, 4'd4);
    tok();
    check("R12 blocked", start_req, 0);
    clr_wait();
    check("R7 held shown", done_flag, 1);
    check("R7 held ack", ack_flag, 0);
    tok();
    check("R12 released", start_req, 1);
    check("R12 page", start_page, 4);
    fin(1'b1);
    check("R7 newer held back", ack_flag, 0);
    clr_wait();
    check("R7 third ack", ack_flag, 1);
    clr_wait();

    // Drop: R10
    issue(C_SEND, 4'd7);
    issue(C_SEND, 4'd8);
    issue(C_DROP, '0);
    tok();
    check("R10 oldest dropped", start_page, 8);
    fin(1'b1);
    clr_wait();
    issue(C_SEND, 4'd7);
    issue(C_SEND, 4'd8);
    issue(C_DROP, '0);
    issue(C_DROP, '0);
    check("R10 both dropped", tx_avail, 1);
    tok();
    check("R10 nothing starts", start_req, 0);
    issue(C_DROP, '0);
    check("R10 drop empty", tx_avail, 1);
    fin(1'b1);
    check("R10 stray done", done_flag, 0);
    issue(C_CLR, '0);
    check("R6 clear when idle", done_flag, 0);
    idle(GAP + 2);

    // Mask and sticky flag: R9 R6, completion during gap: R8
    irq_en = 1'b0;
    issue(C_SEND, 4'd5);
    tok();
    fin(1'b1);
    check("R9 done masked", done_flag, 1);
    check("R9 irq masked", irq, 0);
    tok();
    issue(C_DROP, '0);
    fin(1'b0);
    check("R6 done kept", done_flag, 1);
    @(negedge clk); irq_en = 1'b1; #1;
    check("R9 irq enabled", irq, 1);
    issue(C_CLR, '0);
    issue(C_SEND, 4'd3);
    tok();
    fin(1'b1);
    check("R8 inside gap", done_flag, 0);
    idle(GAP);
    check("R8 after gap", done_flag, 1);
    check("R7 gap result ack", ack_flag, 1);
    clr_wait();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule